// File: doc/BRIEF.md
# Link Packet Receive Checker

This block sits behind the receive side of a serial link and judges every framed packet that arrives from the link partner. Each frame is a run of 32-bit words marked by start and end strobes. The first word carries a sequence number and the second word is the transaction header. Zero or more payload words follow, then an optional end-to-end CRC word, and the last word is the 32-bit link CRC. The block computes both CRCs one word per cycle as the frame streams in. At the last word it settles the verdict in a single step.

The verdict drives the acknowledgment machinery. If the link CRC fails, or the frame is too short to hold one, the block asks for a negative acknowledgment so the partner replays. An intact packet that arrives in sequence order is acknowledged by its sequence number. An intact packet that arrives out of order is a replay of something already taken, so it is dropped without a second acknowledgment. For acknowledged packets, the transaction-level checks (header legality, declared length, end-to-end CRC) raise separate flags. Only a packet that passes every check is reported good for upstream delivery.

The control is a two-state machine. ST_IDLE waits for a start word. ST_FRAME collects words until the end word. The named transitions are: *open* (ST_IDLE to ST_FRAME on a start word without end), *restart* (a start word inside ST_FRAME begins a new frame), *close* (ST_FRAME to ST_IDLE on the end word) and *single* (a start word that is also an end word, which stays in ST_IDLE).

Top module: `lpr_rx_check`

## Requirements
- R1: The link CRC uses polynomial 0x04C11DB7, seeded with all ones, with no final inversion. Each word is fed most significant bit first. It covers every word of the frame except the last, and it must equal the last word.
- R2: A frame that fails the link CRC check, or has fewer than 3 words, pulses nack_req and pkt_bad. In that cycle ack_seq carries the last in-order sequence number accepted, which is 4095 after reset. The frame is not delivered and the expected sequence number does not change.
- R3: A frame with a correct link CRC whose 12-bit sequence number (word 0 bits 11:0) equals the expected number pulses ack_req, with ack_seq equal to that number. The expected number then advances by one, wrapping from 4095 to 0.
- R4: The header is word 1. Bits 9:0 are the declared payload length in words, and bit 15 is the digest bit. If the payload word count (frame words minus 3, minus 1 more when the digest bit is set) differs from the declared length, an acknowledged frame also pulses malformed.
- R5: When the digest bit is set, the second-to-last word is an end-to-end CRC. It uses the same CRC definition, computed over the header and payload words. A mismatch on an acknowledged frame pulses ecrc_err. With the digest bit clear, no end-to-end check is made.
- R6: Header bits 31:29 are the format and bits 28:24 are the type. The pair is legal only when format < 4 and type is 0, 2, 10, or 16 to 23. An illegal pair on an acknowledged frame pulses malformed.
- R7: pkt_good pulses only for an acknowledged frame with neither malformed nor ecrc_err set.
- R8: A frame with a correct link CRC whose sequence number differs from the expected one pulses pkt_bad only. Neither ack_req nor nack_req pulses, and the expected number does not change.
- R9: All verdict outputs are one-cycle pulses, presented in the cycle after the end word is taken. Valid words outside a frame (no start word seen) are ignored.
- R10: A start word that arrives inside an unfinished frame abandons that frame and begins a new one.
- R11: After reset all pulses are low, ack_seq is 0 and the expected sequence number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word present on in_data |
| in_sop | input | 1 | Word is the first of a frame |
| in_eop | input | 1 | Word is the last of a frame (link CRC) |
| in_data | input | 32 | Frame word |
| pkt_good | output | 1 | Packet passes every check and may go upstream |
| pkt_bad | output | 1 | Packet discarded at link level (CRC or order) |
| malformed | output | 1 | Acknowledged packet has bad length or header |
| ecrc_err | output | 1 | Acknowledged packet fails end-to-end CRC |
| ack_req | output | 1 | Request a positive acknowledgment |
| nack_req | output | 1 | Request a negative acknowledgment |
| ack_seq | output | 12 | Sequence number for the requested acknowledgment |

## Verification
A CRC accumulator that folds a word too few or too many times shows up at the next end word. An intact frame then draws a negative acknowledgment instead of a positive one, so the fault is visible one cycle after the first frame ends. A wrong word counter shows up as a false malformed flag, or as an end-to-end check against the wrong word, on the first frame whose payload length hits the fault. A wrong expected-sequence register turns a fresh frame into a silent drop, or makes a replay receive an acknowledgment. That error is exposed on the next frame, and the full wrap of the sequence space is swept to catch faults at the counter's edge.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } lpr_state_e;

    // Fold one word into a running CRC, most significant bit first.
    function automatic logic [WORD_W-1:0] crc_fold(
        input logic [WORD_W-1:0] crc_in,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[WORD_W-1] ^ word[i];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/lpr_crc_acc.sv
module lpr_crc_acc
    import lpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fold_en,
    input  logic [WORD_W-1:0] fold_word,
    output logic [WORD_W-1:0] peek_crc
);
    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= CRC_SEED;
        else if (clear)   acc_q <= CRC_SEED;
        else if (fold_en) acc_q <= crc_fold(acc_q, fold_word);
    end

    // Value the accumulator would hold once fold_word is included.
    assign peek_crc = crc_fold(acc_q, fold_word);
endmodule

// File: rtl/lpr_hdr_legal.sv
module lpr_hdr_legal (
    input  logic [2:0] fmt,
    input  logic [4:0] kind,
    output logic       legal
);
    logic kind_ok;

    always_comb begin
        unique case (kind) inside
            5'd0, 5'd2, 5'd10: kind_ok = 1'b1;
            [5'd16:5'd23]:     kind_ok = 1'b1;
            default:           kind_ok = 1'b0;
        endcase
        legal = !fmt[2] && kind_ok;
    end
endmodule

// File: rtl/lpr_seq_track.sv
module lpr_seq_track #(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [SEQ_W-1:0] expect_seq,
    output logic [SEQ_W-1:0] last_good
);
    logic [SEQ_W-1:0] next_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       next_q <= '0;
        else if (advance) next_q <= next_q + 1'b1;
    end

    assign expect_seq = next_q;
    assign last_good  = next_q - 1'b1;
endmodule

// File: rtl/lpr_rx_check.sv
module lpr_rx_check
    import lpr_pkg::*;
#(
    parameter int SEQ_W = 12,
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    output logic              pkt_good,
    output logic              pkt_bad,
    output logic              malformed,
    output logic              ecrc_err,
    output logic              ack_req,
    output logic              nack_req,
    output logic [SEQ_W-1:0]  ack_seq
);
    localparam int CNT_W = LEN_W + 2;
    localparam logic [CNT_W-1:0] CNT_CAP = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] MIN_WORDS = CNT_W'(3);

    lpr_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q, idx, nwords, payload, need;
    logic [WORD_W-1:0] prev1_q, prev2_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [2:0]        fmt_q;
    logic [4:0]        kind_q;
    logic              dig_q;
    logic [LEN_W-1:0]  len_q;

    logic accept, first, last;
    logic runt, lcrc_ok, len_ok, hdr_ok, mal, ecrc_bad, in_order, advance;
    logic [WORD_W-1:0] lcrc_peek, ecrc_peek;
    logic [SEQ_W-1:0]  expect_seq, last_good;

    assign accept = in_valid && (in_sop || state_q == ST_FRAME);
    assign first  = in_valid && in_sop;
    assign last   = accept && in_eop;
    assign idx    = first ? '0 : cnt_q;
    assign nwords = idx + 1'b1;

    // ---------------- state register ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (first && !in_eop) state_d = ST_FRAME;   // open
            ST_FRAME: if (last)             state_d = ST_IDLE;    // close
                      else if (first)       state_d = ST_FRAME;   // restart
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- frame capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            prev1_q <= '0;
            prev2_q <= '0;
            seq_q   <= '0;
            fmt_q   <= '0;
            kind_q  <= '0;
            dig_q   <= 1'b0;
            len_q   <= '0;
        end else if (accept) begin
            prev2_q <= prev1_q;
            prev1_q <= in_data;
            cnt_q   <= (nwords >= CNT_CAP) ? CNT_CAP : nwords;
            if (idx == CNT_W'(0)) seq_q <= in_data[SEQ_W-1:0];
            if (idx == CNT_W'(1)) begin
                fmt_q  <= in_data[31:29];
                kind_q <= in_data[28:24];
                dig_q  <= in_data[15];
                len_q  <= in_data[LEN_W-1:0];
            end
        end
    end

    lpr_crc_acc u_lcrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (first),
        .fold_en   (accept && !first),
        .fold_word (prev1_q),
        .peek_crc  (lcrc_peek)
    );

    lpr_crc_acc u_ecrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (first),
        .fold_en   (accept && !first && idx >= CNT_W'(3)),
        .fold_word (prev2_q),
        .peek_crc  (ecrc_peek)
    );

    lpr_hdr_legal u_legal (
        .fmt   (fmt_q),
        .kind  (kind_q),
        .legal (hdr_ok)
    );

    lpr_seq_track #(.SEQ_W(SEQ_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .expect_seq (expect_seq),
        .last_good  (last_good)
    );

    // ---------------- end-of-frame verdict ----------------
    always_comb begin
        runt     = nwords < MIN_WORDS;
        lcrc_ok  = !runt && (in_data == lcrc_peek);
        need     = MIN_WORDS + CNT_W'(dig_q);
        payload  = nwords - need;
        len_ok   = (nwords >= need) && (payload == CNT_W'(len_q));
        mal      = !len_ok || !hdr_ok;
        ecrc_bad = dig_q && (nwords >= CNT_W'(4)) && (prev1_q != ecrc_peek);
        in_order = (seq_q == expect_seq);
        advance  = last && lcrc_ok && in_order;
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_good  <= 1'b0;
            pkt_bad   <= 1'b0;
            malformed <= 1'b0;
            ecrc_err  <= 1'b0;
            ack_req   <= 1'b0;
            nack_req  <= 1'b0;
            ack_seq   <= '0;
        end else begin
            pkt_good  <= 1'b0;
            pkt_bad   <= 1'b0;
            malformed <= 1'b0;
            ecrc_err  <= 1'b0;
            ack_req   <= 1'b0;
            nack_req  <= 1'b0;
            if (last) begin
                if (!lcrc_ok) begin
                    nack_req <= 1'b1;
                    pkt_bad  <= 1'b1;
                    ack_seq  <= last_good;
                end else if (!in_order) begin
                    pkt_bad  <= 1'b1;
                end else begin
                    ack_req   <= 1'b1;
                    ack_seq   <= seq_q;
                    malformed <= mal;
                    ecrc_err  <= ecrc_bad;
                    pkt_good  <= !mal && !ecrc_bad;
                end
            end
        end
    end
endmodule

// File: rtl/lpr_rx_check_sva.sv
module lpr_rx_check_sva (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_eop,
    input logic pkt_good,
    input logic pkt_bad,
    input logic malformed,
    input logic ecrc_err,
    input logic ack_req,
    input logic nack_req
);
    // R2: a negative acknowledgment is a discard, never paired with a positive one
    a_r2_nack_discards: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |-> (pkt_bad && !ack_req && !pkt_good));

    // R7: a good packet is always acknowledged and clean
    a_r7_good_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |-> (ack_req && !malformed && !ecrc_err));

    // R8: a discard without negative acknowledgment draws no acknowledgment
    a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bad && !nack_req) |-> !ack_req);

    // R4: transaction flags only accompany an acknowledgment
    a_r4_flags_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (malformed || ecrc_err) |-> ack_req);

    // R9: verdicts follow an accepted end word
    a_r9_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req || nack_req || pkt_bad) |-> $past(in_valid && in_eop));

    // R9: an acknowledgment is a single-cycle pulse
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);

    // R7: good and bad status never together
    a_r7_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_good, pkt_bad}));
endmodule

bind lpr_rx_check lpr_rx_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .pkt_good  (pkt_good),
    .pkt_bad   (pkt_bad),
    .malformed (malformed),
    .ecrc_err  (ecrc_err),
    .ack_req   (ack_req),
    .nack_req  (nack_req)
);

// File: tb/tb_lpr_rx_check.sv
module tb_lpr_rx_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic        pkt_good, pkt_bad, malformed, ecrc_err, ack_req, nack_req;
    logic [11:0] ack_seq;

    always #10 clk = ~clk;   // 50 MHz

    lpr_rx_check dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .pkt_good(pkt_good),
        .pkt_bad(pkt_bad), .malformed(malformed), .ecrc_err(ecrc_err),
        .ack_req(ack_req), .nack_req(nack_req), .ack_seq(ack_seq)
    );

    int compared = 0, mismatched = 0, cyc = 0;
    bit done = 0;
    logic [11:0] exp_next = 12'd0;
    logic [11:0] last_rep = 12'd0;
    logic [31:0] w [0:15];
    int n;

    function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ 32'h04C11DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h (good,bad,mal,ecrc,ack,nack,seq)", req, act, exp);
        end
    endtask

    function automatic logic [17:0] outs();
        return {pkt_good, pkt_bad, malformed, ecrc_err, ack_req, nack_req, ack_seq};
    endfunction

    task automatic drive_words(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == cnt - 1); in_data = w[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    endtask

    // Build, send and check one complete frame.
    task automatic run_frame(input string req, input logic [11:0] seq, input logic [2:0] fmt,
                             input logic [4:0] typ, input bit dig, input logic [9:0] len,
                             input int npay, input bit bad_l, input bit bad_e);
        logic [31:0] c;
        bit legal, mal, ebad;
        logic [17:0] e;
        w[0] = {20'h0, seq};
        w[1] = {fmt, typ, 8'h3C, dig, 5'h0, len};
        for (int i = 0; i < npay; i++) w[2+i] = 32'hA500_0000 ^ {8'h0, seq, 12'h0} ^ (i * 32'h0101_0101);
        n = 2 + npay;
        if (dig) begin
            c = 32'hFFFF_FFFF;
            for (int i = 1; i < n; i++) c = tb_crc(c, w[i]);
            w[n] = bad_e ? ~c : c;
            n++;
        end
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) c = tb_crc(c, w[i]);
        w[n] = bad_l ? (c ^ 32'h0000_0100) : c;
        n++;
        drive_words(n);
        legal = (fmt < 3'd4) && (typ == 5'd0 || typ == 5'd2 || typ == 5'd10 || typ[4:3] == 2'b10);
        if (bad_l) begin
            e = {6'b010001, exp_next - 12'd1};
            last_rep = exp_next - 12'd1;
        end else if (seq != exp_next) begin
            e = {6'b010000, last_rep};
        end else begin
            mal  = !legal || (int'(len) != npay);
            ebad = dig && bad_e;
            e = {!mal && !ebad, 1'b0, mal, ebad, 2'b10, seq};
            last_rep = seq;
            exp_next = exp_next + 12'd1;
        end
        check(req, outs(), e);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", outs(), 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", outs(), 18'h0);

        // R1 R3 R4 R5 R7: clean frames, payload 0..6, digest off and on
        for (int d = 0; d < 2; d++)
            for (int p = 0; p <= 6; p++)
                run_frame("R3 clean frame", exp_next, 3'd2, 5'd0, bit'(d), 10'(p), p, 0, 0);

        // R4: declared length off by one either way
        run_frame("R4 length short", exp_next, 3'd0, 5'd0, 0, 10'd3, 2, 0, 0);
        run_frame("R4 length long", exp_next, 3'd1, 5'd2, 1, 10'd1, 2, 0, 0);
        run_frame("R4 zero declared", exp_next, 3'd0, 5'd0, 0, 10'd0, 1, 0, 0);

        // R6: every format/type pair
        for (int f = 0; f < 8; f++)
            for (int t = 0; t < 32; t++)
                run_frame("R6 fmt/type", exp_next, 3'(f), 5'(t), 0, 10'd1, 1, 0, 0);

        // R5: end-to-end CRC error, and digest clear ignores it
        run_frame("R5 ecrc bad", exp_next, 3'd2, 5'd0, 1, 10'd3, 3, 0, 1);
        run_frame("R5 ecrc bad no payload", exp_next, 3'd0, 5'd10, 1, 10'd0, 0, 0, 1);
        run_frame("R5 digest clear", exp_next, 3'd2, 5'd0, 0, 10'd3, 3, 0, 1);

        // R2: link CRC error, also when the frame is otherwise malformed
        run_frame("R2 lcrc bad", exp_next, 3'd2, 5'd0, 0, 10'd2, 2, 1, 0);
        run_frame("R2 lcrc bad twice", exp_next, 3'd7, 5'd31, 1, 10'd5, 1, 1, 1);
        run_frame("R2 next frame still expected", exp_next, 3'd2, 5'd0, 0, 10'd1, 1, 0, 0);

        // R2: runt frames of 1 and 2 words
        for (int r = 1; r <= 2; r++) begin
            for (int i = 0; i < r; i++) w[i] = {20'h0, exp_next};
            drive_words(r);
            check("R2 runt", outs(), {6'b010001, exp_next - 12'd1});
            last_rep = exp_next - 12'd1;
        end

        // R8: replay of old and future sequence numbers
        run_frame("R8 replay old", exp_next - 12'd1, 3'd2, 5'd0, 0, 10'd1, 1, 0, 0);
        run_frame("R8 ahead", exp_next + 12'd5, 3'd2, 5'd0, 0, 10'd1, 1, 0, 0);
        run_frame("R8 in order after drop", exp_next, 3'd2, 5'd0, 0, 10'd1, 1, 0, 0);

        // R9: stray words with no start are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 2); in_data = 32'hDEAD_0000 + i;
            @(negedge clk);
            in_valid = 1'b0; in_eop = 1'b0;
            check("R9 stray word", {outs()} & 18'h3F000, 18'h0);
        end
        run_frame("R9 frame after strays", exp_next, 3'd2, 5'd0, 0, 10'd2, 2, 0, 0);

        // R10: unfinished frame abandoned by a new start
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = 1'b0; in_data = 32'h1234_0000 + i;
        end
        run_frame("R10 restart", exp_next, 3'd2, 5'd0, 1, 10'd2, 2, 0, 0);

        // R3: walk the sequence space through its wrap
        while (exp_next != 12'd4094)
            run_frame("R3 walk", exp_next, 3'd0, 5'd0, 0, 10'd0, 0, 0, 0);
        for (int i = 0; i < 4; i++)
            run_frame("R3 wrap", exp_next, 3'd0, 5'd0, 0, 10'd0, 0, 0, 0);
        run_frame("R2 nack after wrap", exp_next, 3'd0, 5'd0, 0, 10'd0, 0, 1, 0);
        run_frame("R8 replay across wrap", 12'd4095, 3'd0, 5'd0, 0, 10'd0, 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule